// File: doc/BRIEF.md
# Prescaled Timer Counter

This block is a free-running 32-bit event timer for a peripheral subsystem. Every cycle of the peripheral clock feeds a prescale counter. That counter runs from zero up to a programmable limit and then starts again at zero. Each time it completes a pass, the main count advances by one. The main count rolls over from all ones to zero without any side effect. Software starts the timer, stops it and zeroes it through a small control word. It can also preload both the main count and the prescale limit at any time.

A separate flag word collects capture events. Each capture input line sets its own sticky flag. Software clears a flag by writing a one to that flag's bit position. The interrupt output is high whenever any flag is set.

All access goes through a simple word-addressed register port. A request is taken on a clock edge, and the acknowledge and any read data appear on the following cycle.

Top module: `prescaled_timer`

## Requirements
- R1: After reset, the flag word, control word, main count and prescale limit all read 0, and `irq` is low.
- R2: Control bit 0 (enable) lets the prescale counter and the main count advance. While it is 0, both counters keep their values.
- R3: With prescale limit P, the main count advances by exactly one every P+1 enabled cycles, counting from a zero prescale state. The count never moves by more than one per cycle unless software loads it.
- R4: While control bit 1 (clear) is 1, both counters are forced to zero on every clock edge, whatever the enable bit is. They count again from zero once software writes the bit back to 0.
- R5: The main count rolls over from 0xFFFFFFFF to 0x00000000, and the rollover sets no flag.
- R6: A software load of the main count (offset 0x8) in a counting cycle wins over that cycle's increment.
- R7: Reaching the limit is a terminal count. When the prescale count is equal to or above the limit in a counting cycle, the prescale counter returns to 0 and the main count advances. This also applies when the limit has just been lowered below the running prescale count.
- R8: A high on capture input `cap_evt[i]` sets flag bit i of the flag word (offset 0x0). Each flag stays set until it is cleared. `irq` is the OR of all flags.
- R9: Writing 1 to flag bit i clears that flag, and writing 0 leaves it unchanged. When a capture event and a clear reach the same flag in the same cycle, the flag stays set.
- R10: Control bits 31:2 and flag bits above the capture channel count read as 0, and writes to them have no effect.
- R11: Register offsets are: flags 0x0, control 0x4, main count 0x8, prescale limit 0xC. A request sampled on one edge is acknowledged in the next cycle, and a read returns the register value from just before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_ack` is high |
| bus_ack | output | 1 | Access completed, one cycle after the request |
| cap_evt | input | 4 | Capture event pulses, one per channel |
| irq | output | 1 | High while any capture flag is set |

## Verification
A faulty prescale counter changes the number of enabled cycles between main-count steps. The difference is visible in the count that is read back after a stop, and in a run with a small limit it shows within a few cycles. A broken clear path or enable path leaves a non-zero or drifting count, which a read taken while the timer is held or stopped exposes at once. Flag errors, such as a lost capture, a clear that beats a simultaneous event, or a bit set by rollover, show up in the next read of the flag word and on `irq` in the same cycle.

// File: rtl/ptm_pkg.sv
// Package: shared register selector and control-bit positions for the
// prescaled timer. Assumes a word-aligned register port with four registers.
package ptm_pkg;

    // Register selected by address bits [3:2]
    typedef enum logic [1:0] {
        SEL_FLAGS = 2'd0,
        SEL_CTRL  = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_LIMIT = 2'd3
    } reg_sel_e;

    // Control word bit positions
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_CLR_BIT = 1;
    localparam int CTRL_USED_W  = 2;

endpackage

// File: rtl/ptm_bus_port.sv
// Module: ptm_bus_port
// Decodes register requests into write strobes and returns registered read
// data with a one-cycle acknowledge.
// Assumes AW >= 4 and word-aligned offsets. Address bits above bit 3 must be
// zero for a hit. Unused and reserved bits read as zero.
module ptm_bus_port
    import ptm_pkg::*;
#(
    parameter int DW   = 32,
    parameter int AW   = 4,
    parameter int NCAP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_req,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_rdata,
    output logic            bus_ack,
    output logic            wr_flags,
    output logic            wr_ctrl,
    output logic            wr_count,
    output logic            wr_limit,
    input  logic [NCAP-1:0] flags_q,
    input  logic            ctrl_en,
    input  logic            ctrl_clr,
    input  logic [DW-1:0]   count_q,
    input  logic [DW-1:0]   limit_q
);

    localparam int SEL_LSB = 2;
    localparam int SEL_W   = 2;
    localparam int HI_LSB  = SEL_LSB + SEL_W;
    localparam int HI_W    = AW - HI_LSB;

    logic           hi_ok;
    logic           hit;
    reg_sel_e       sel;
    logic [DW-1:0]  rd_val;

    // Upper address bits must be zero when present
    generate
        if (HI_W > 0) begin : g_hi
            assign hi_ok = (bus_addr[AW-1:HI_LSB] == '0);
        end else begin : g_nohi
            assign hi_ok = 1'b1;
        end
    endgenerate

    assign hit = hi_ok && (bus_addr[SEL_LSB-1:0] == '0);
    assign sel = reg_sel_e'(bus_addr[HI_LSB-1:SEL_LSB]);

    // Write strobe decode, one strobe per register
    always_comb begin
        wr_flags = 1'b0;
        wr_ctrl  = 1'b0;
        wr_count = 1'b0;
        wr_limit = 1'b0;
        if (bus_req && bus_we && hit) begin
            case (sel)
                SEL_FLAGS: wr_flags = 1'b1;
                SEL_CTRL:  wr_ctrl  = 1'b1;
                SEL_COUNT: wr_count = 1'b1;
                SEL_LIMIT: wr_limit = 1'b1;
                default:   wr_flags = 1'b0;
            endcase
        end
    end

    // Read multiplexer with zero-filled reserved bits
    always_comb begin
        rd_val = '0;
        case (sel)
            SEL_FLAGS: rd_val[NCAP-1:0] = flags_q;
            SEL_CTRL: begin
                rd_val[CTRL_EN_BIT]  = ctrl_en;
                rd_val[CTRL_CLR_BIT] = ctrl_clr;
            end
            SEL_COUNT: rd_val = count_q;
            SEL_LIMIT: rd_val = limit_q;
            default:   rd_val = '0;
        endcase
    end

    // Registered read data and acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_ack   <= 1'b0;
        end else begin
            bus_ack <= bus_req;
            if (bus_req && !bus_we) begin
                bus_rdata <= hit ? rd_val : '0;
            end
        end
    end

endmodule

// File: rtl/ptm_ctrl_regs.sv
// Module: ptm_ctrl_regs
// Holds the control word (enable, clear), the prescale limit and the sticky
// capture flags. A flag is cleared by writing one to its bit. A capture event
// in the same cycle keeps the flag set.
// Assumes cap_evt is already synchronous to clk.
module ptm_ctrl_regs
    import ptm_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NCAP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_flags,
    input  logic            wr_ctrl,
    input  logic            wr_limit,
    input  logic [DW-1:0]   wdata,
    input  logic [NCAP-1:0] cap_evt,
    output logic            ctrl_en,
    output logic            ctrl_clr,
    output logic [DW-1:0]   limit_q,
    output logic [NCAP-1:0] flags_q
);

    // Control word: only the two defined bits are stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en  <= 1'b0;
            ctrl_clr <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl_en  <= wdata[CTRL_EN_BIT];
            ctrl_clr <= wdata[CTRL_CLR_BIT];
        end
    end

    // Prescale limit register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= '0;
        end else if (wr_limit) begin
            limit_q <= wdata;
        end
    end

    // One sticky flag per capture channel
    generate
        for (genvar i = 0; i < NCAP; i++) begin : g_flag
            // Event sets, write-one clears, event has priority
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flags_q[i] <= 1'b0;
                end else if (cap_evt[i]) begin
                    flags_q[i] <= 1'b1;
                end else if (wr_flags && wdata[i]) begin
                    flags_q[i] <= 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/ptm_prescaler.sv
// Module: ptm_prescaler
// Counts enabled cycles from zero up to the limit and raises a one-cycle
// tick on the terminal cycle. A count at or above the limit is terminal, so
// lowering the limit below the running count wraps on the next enabled cycle.
// Assumes clr has priority over run.
module ptm_prescaler #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clr,
    input  logic [DW-1:0] limit_q,
    output logic [DW-1:0] pc_q,
    output logic          tick
);

    logic at_end;

    assign at_end = (pc_q >= limit_q);
    assign tick   = run && at_end;

    // Prescale count: clear, wrap on terminal, else step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (clr) begin
            pc_q <= '0;
        end else if (run) begin
            pc_q <= at_end ? '0 : pc_q + 1'b1;
        end
    end

endmodule

// File: rtl/ptm_counter.sv
// Module: ptm_counter
// Main count: cleared while clr is high, loaded by software, else advanced
// by one per prescale tick with natural rollover.
// Priority: clear, then load, then tick.
module ptm_counter #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          tick,
    output logic [DW-1:0] count_q
);

    // Main count update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (tick) begin
            count_q <= count_q + 1'b1;
        end
    end

endmodule

// File: rtl/prescaled_timer.sv
// Module: prescaled_timer (top)
// Ties the register port, the control registers, the prescaler and the main
// count together. The enable bit gates both counters. The clear bit
// overrides them. irq is the OR of all capture flags.
// Assumes a single clock domain and synchronous active-low reset.
module prescaled_timer #(
    parameter int DW   = 32,
    parameter int AW   = 4,
    parameter int NCAP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_req,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            bus_ack,
    input  logic [NCAP-1:0] cap_evt,
    output logic            irq
);

    logic            wr_flags;
    logic            wr_ctrl;
    logic            wr_count;
    logic            wr_limit;
    logic            ctrl_en;
    logic            ctrl_clr;
    logic [DW-1:0]   limit_q;
    logic [NCAP-1:0] flags_q;
    logic [DW-1:0]   pc_q;
    logic            tick;
    logic            run;
    logic [DW-1:0]   count_q;

    assign run = ctrl_en && !ctrl_clr;
    assign irq = |flags_q;

    ptm_bus_port #(.DW(DW), .AW(AW), .NCAP(NCAP)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_req  (bus_req),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_rdata(bus_rdata),
        .bus_ack  (bus_ack),
        .wr_flags (wr_flags),
        .wr_ctrl  (wr_ctrl),
        .wr_count (wr_count),
        .wr_limit (wr_limit),
        .flags_q  (flags_q),
        .ctrl_en  (ctrl_en),
        .ctrl_clr (ctrl_clr),
        .count_q  (count_q),
        .limit_q  (limit_q)
    );

    ptm_ctrl_regs #(.DW(DW), .NCAP(NCAP)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_flags(wr_flags),
        .wr_ctrl (wr_ctrl),
        .wr_limit(wr_limit),
        .wdata   (bus_wdata),
        .cap_evt (cap_evt),
        .ctrl_en (ctrl_en),
        .ctrl_clr(ctrl_clr),
        .limit_q (limit_q),
        .flags_q (flags_q)
    );

    ptm_prescaler #(.DW(DW)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .clr    (ctrl_clr),
        .limit_q(limit_q),
        .pc_q   (pc_q),
        .tick   (tick)
    );

    ptm_counter #(.DW(DW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ctrl_clr),
        .load    (wr_count),
        .load_val(bus_wdata),
        .tick    (tick),
        .count_q (count_q)
    );

endmodule

// File: rtl/ptm_checker.sv
// Module: ptm_checker
// Temporal properties of the prescaled timer, attached by bind.
// Observes the control state, both counters and the capture flags.
module ptm_checker #(
    parameter int DW   = 32,
    parameter int NCAP = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ctrl_en,
    input logic            ctrl_clr,
    input logic            wr_count,
    input logic [DW-1:0]   count_q,
    input logic [DW-1:0]   pc_q,
    input logic [NCAP-1:0] flags_q,
    input logic [NCAP-1:0] cap_evt
);

    // R4
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_clr |=> (count_q == '0) && (pc_q == '0));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !ctrl_clr && !wr_count) |=> $stable(count_q) && $stable(pc_q));

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_clr && !wr_count) |=> ((count_q - $past(count_q)) <= DW'(1)));

    // R8
    capture_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt != '0) |=> ((flags_q & $past(cap_evt)) == $past(cap_evt)));

    // R5
    no_spurious_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_q & ~$past(flags_q) & ~$past(cap_evt)) == '0));

endmodule

bind prescaled_timer ptm_checker #(.DW(DW), .NCAP(NCAP)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_en (ctrl_en),
    .ctrl_clr(ctrl_clr),
    .wr_count(wr_count),
    .count_q (count_q),
    .pc_q    (pc_q),
    .flags_q (flags_q),
    .cap_evt (cap_evt)
);

// File: tb/test_prescaled_timer.sv
// Scoreboard bench: bus tasks push one expected item per access, and a
// monitor pops an item on every acknowledge and compares read data.
module test_prescaled_timer;

    localparam logic [3:0] A_FLAGS = 4'h0;
    localparam logic [3:0] A_CTRL  = 4'h4;
    localparam logic [3:0] A_COUNT = 4'h8;
    localparam logic [3:0] A_LIMIT = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack;
    logic [3:0]  cap_evt = '0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    bit          q_rd[$];
    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #5 clk = ~clk;

    prescaled_timer i_prescaled_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_req  (bus_req),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .bus_ack  (bus_ack),
        .cap_evt  (cap_evt),
        .irq      (irq)
    );

    // Monitor: one scoreboard item per acknowledge
    always @(negedge clk) begin
        if (rst_n && bus_ack) begin
            if (q_rd.size() == 0) begin
                total++;
                bad++;
                $display("FAIL R11: ack with no pending access (actual ack=1 expected ack=0)");
            end else begin
                bit          rd;
                logic [31:0] ex;
                string       tg;
                rd = q_rd.pop_front();
                ex = q_exp.pop_front();
                tg = q_tag.pop_front();
                if (rd) begin
                    total++;
                    if (bus_rdata !== ex) begin
                        bad++;
                        $display("FAIL %s: actual=0x%08h expected=0x%08h", tg, bus_rdata, ex);
                    end
                end
            end
        end
    end

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        q_rd.push_back(1'b0);
        q_exp.push_back('0);
        q_tag.push_back("wr");
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, input logic [31:0] ex, input string tg);
        q_rd.push_back(1'b1);
        q_exp.push_back(ex);
        q_tag.push_back(tg);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_irq(input logic ex, input string tg);
        total++;
        if (irq !== ex) begin
            bad++;
            $display("FAIL %s: irq actual=%0b expected=%0b", tg, irq, ex);
        end
    endtask

    // Clear, load limit and start value, run m idle cycles, stop and read
    task automatic run_count(input logic [31:0] lim, input logic [31:0] start,
                             input int m, input string tg);
        logic [31:0] ex;
        bus_wr(A_CTRL, 32'h2);
        bus_wr(A_CTRL, 32'h0);
        bus_wr(A_LIMIT, lim);
        bus_wr(A_COUNT, start);
        bus_wr(A_CTRL, 32'h1);
        idle(m);
        bus_wr(A_CTRL, 32'h0);
        ex = start + 32'((m + 1) / (int'(lim) + 1));
        bus_rd(A_COUNT, ex, tg);
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        bus_rd(A_FLAGS, 32'h0, "R1 flags");
        bus_rd(A_CTRL,  32'h0, "R1 ctrl");
        bus_rd(A_COUNT, 32'h0, "R1 count");
        bus_rd(A_LIMIT, 32'h0, "R1 limit");
        chk_irq(1'b0, "R1 irq");

        // R10 reserved control bits; R11 limit offset
        bus_wr(A_CTRL, 32'hFFFF_FFF0);
        bus_rd(A_CTRL, 32'h0, "R10 ctrl reserved");
        bus_wr(A_LIMIT, 32'd3);
        bus_rd(A_LIMIT, 32'd3, "R11 limit readback");

        // R3 limit 3: 21 enabled cycles give 5 steps
        bus_wr(A_CTRL, 32'h1);
        idle(20);
        bus_wr(A_CTRL, 32'h0);
        bus_rd(A_COUNT, 32'd5, "R3 limit3 count");
        // R2 stopped counter holds
        idle(10);
        bus_rd(A_COUNT, 32'd5, "R2 hold while disabled");

        // R4 clear held with enable set
        bus_wr(A_CTRL, 32'h3);
        idle(5);
        bus_rd(A_COUNT, 32'd0, "R4 count held at zero");
        bus_rd(A_CTRL, 32'h3, "R4 ctrl readback");
        bus_wr(A_CTRL, 32'h1);
        idle(6);
        bus_wr(A_CTRL, 32'h0);
        bus_rd(A_COUNT, 32'd1, "R4 resume from zero");

        // R3 more limits
        run_count(32'd0, 32'd0, 9, "R3 limit0");
        run_count(32'd6, 32'd40, 30, "R3 limit6 preload");
        run_count(32'd1, 32'd7, 0, "R3 limit1 single cycle");

        // R5 rollover with no flag
        run_count(32'd0, 32'hFFFF_FFFE, 2, "R5 rollover");
        bus_rd(A_FLAGS, 32'h0, "R5 no flag on rollover");
        chk_irq(1'b0, "R5 irq low");

        // R6 load beats increment
        bus_wr(A_CTRL, 32'h2);
        bus_wr(A_CTRL, 32'h0);
        bus_wr(A_LIMIT, 32'd0);
        bus_wr(A_CTRL, 32'h1);
        idle(3);
        bus_wr(A_COUNT, 32'd100);
        bus_wr(A_CTRL, 32'h0);
        bus_rd(A_COUNT, 32'd101, "R6 load priority");

        // R7 limit lowered below running prescale count
        bus_wr(A_CTRL, 32'h2);
        bus_wr(A_CTRL, 32'h0);
        bus_wr(A_LIMIT, 32'd9);
        bus_wr(A_CTRL, 32'h1);
        idle(4);
        bus_wr(A_LIMIT, 32'd2);
        bus_wr(A_CTRL, 32'h0);
        bus_rd(A_COUNT, 32'd1, "R7 lowered limit wraps");

        // R8 capture sets flags
        cap_evt = 4'b0100;
        @(negedge clk);
        cap_evt = 4'b0000;
        chk_irq(1'b1, "R8 irq high");
        bus_rd(A_FLAGS, 32'h4, "R8 flag 2");
        cap_evt = 4'b1001;
        @(negedge clk);
        cap_evt = 4'b0000;
        bus_rd(A_FLAGS, 32'hD, "R8 flags 0 2 3");

        // R9 write-one-to-clear; zero bits leave flags alone
        bus_wr(A_FLAGS, 32'h4);
        bus_rd(A_FLAGS, 32'h9, "R9 clear flag 2");
        bus_wr(A_FLAGS, 32'h0);
        bus_rd(A_FLAGS, 32'h9, "R9 zero write no effect");
        cap_evt = 4'b0010;
        @(negedge clk);
        cap_evt = 4'b0010;
        bus_wr(A_FLAGS, 32'h2);
        cap_evt = 4'b0000;
        bus_rd(A_FLAGS, 32'hB, "R9 event wins over clear");

        // R10 upper flag bits ignored; clear all
        bus_wr(A_FLAGS, 32'hFFFF_FFFF);
        bus_rd(A_FLAGS, 32'h0, "R10 flags cleared upper zero");
        chk_irq(1'b0, "R9 irq low after clear");

        idle(3);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule